// File: doc/BRIEF.md
# Processor power mode sequencer

The sequencer moves a processor subsystem between six operating modes. Three are run modes: full speed, PLL bypassed, and PLL powered down. Three are low-power modes: core clock gated, both clocks gated, and internal supply removed. It drives the PLL enable and bypass, the core and system clock gates, a slow-rate select for the system clock, the internal-supply enable and the SDRAM self-refresh request. The PLL lock, the self-refresh handshake and the supply-good signal come back as acknowledge inputs, and each step of a sequence waits on the matching acknowledge.

Software asks for a mode with a one-cycle request carrying a 3-bit mode code. It may stage a new PLL multiplier while in one of the two bypassed run modes. The staged multiplier takes effect only when full speed is next entered. Peripheral interrupts and an RTC event wake the low-power modes, and the asynchronous reset returns everything to full speed. The block also reports whether DMA into L1 memory may proceed.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block reports mode 0 and idle. PLL enable is 1, bypass is 0, core and system clocks are enabled, slow select is 0, supply enable is 1, self-refresh request is 0, DMA is allowed, and the applied multiplier equals MULT_DEF.
- R2: A request for mode 1 (bypassed) from mode 0 sets bypass and keeps the PLL and both clocks running. A request for mode 0 turns the PLL on, waits for lock, and then clears bypass. When idle in mode 0, the PLL is on, bypass is clear and both clocks run.
- R3: Mode 2 (PLL off) is accepted only from mode 1. It clears PLL enable, keeps bypass set, keeps both clocks running and keeps DMA allowed. A request for mode 1 from mode 2 waits for PLL lock.
- R4: A multiplier write is accepted only while idle in mode 1 or 2. It changes the applied multiplier only on the next entry to mode 0. Writes in any other mode are ignored.
- R5: A request for mode 3 (sleep) first raises the self-refresh request and refuses DMA. Only after the self-refresh acknowledge does it gate the core clock. The system clock stays on with slow select set, and the PLL enable is unchanged.
- R6: Mode 4 (deep sleep) gates both clocks. A peripheral interrupt has no effect there; only the RTC event or reset leaves it.
- R7: Mode 5 (hibernate) gates both clocks and turns off the PLL and the internal supply. An interrupt or RTC event raises the supply enable first. Clocks return only after the supply-good acknowledge, and both the applied and staged multipliers return to MULT_DEF.
- R8: On wake from modes 3, 4 or 5, clocks are re-enabled and PLL lock is awaited before the self-refresh request falls. The block returns to mode 0, allowing DMA, once the self-refresh acknowledge falls.
- R9: Mode codes are 0 to 5 as above; codes 6 and 7 are invalid. A request is ignored when the block is not idle, when its code is invalid, or when it names the current mode.
- R10: Asserting reset from any mode, including a low-power mode, restores the R1 state and discards the staged multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 3 | Requested mode code |
| mult_we_i | input | 1 | Multiplier write strobe |
| mult_i | input | MULT_W | Multiplier value to stage |
| irq_wake_i | input | 1 | Peripheral interrupt wake |
| rtc_wake_i | input | 1 | RTC event wake |
| pll_lock_i | input | 1 | PLL locked acknowledge |
| sr_ack_i | input | 1 | SDRAM self-refresh acknowledge |
| vint_ok_i | input | 1 | Internal supply good |
| pll_en_o | output | 1 | PLL enable |
| pll_bypass_o | output | 1 | PLL bypass select |
| cclk_en_o | output | 1 | Core clock enable |
| sclk_en_o | output | 1 | System clock enable |
| sclk_slow_o | output | 1 | System clock reduced-rate select |
| vint_en_o | output | 1 | Internal supply enable |
| sr_req_o | output | 1 | SDRAM self-refresh request |
| mult_o | output | MULT_W | Applied PLL multiplier |
| mode_o | output | 3 | Current mode code |
| idle_o | output | 1 | No transition in progress |
| dma_l1_ok_o | output | 1 | DMA into L1 memory allowed |

## Verification
The assertions check several relations on every cycle. A core clock gate never falls unless the self-refresh acknowledge was present. Self-refresh is never released before the clocks and PLL lock are back. A dropped supply always comes with gated clocks and PLL. Deep sleep holds without an RTC event, and the applied multiplier moves only at a full-speed entry or a supply restore. The bench scenarios cover the rest: which requests and multiplier writes are ignored in which mode, the value the multiplier takes after a bypassed-to-full transition and after hibernate, the supply-before-clocks order on wake, and recovery by reset from a low-power mode.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FULL  = 3'd0,
    MODE_ACT   = 3'd1,
    MODE_NOPLL = 3'd2,
    MODE_SLEEP = 3'd3,
    MODE_DEEP  = 3'd4,
    MODE_HIBER = 3'd5
  } pm_mode_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_LOCK,
    SEQ_SR_IN,
    SEQ_PARKED,
    SEQ_VINT_UP,
    SEQ_SR_OUT
  } seq_step_e;

  typedef struct packed {
    logic pll_en;
    logic pll_bypass;
    logic cclk_en;
    logic sclk_en;
    logic sclk_slow;
    logic vint_en;
    logic sr_req;
  } pwr_ctl_t;

  localparam pwr_ctl_t CTL_RESET = '{
    pll_en: 1'b1, pll_bypass: 1'b0, cclk_en: 1'b1, sclk_en: 1'b1,
    sclk_slow: 1'b0, vint_en: 1'b1, sr_req: 1'b0
  };

  function automatic logic is_run_mode(input pm_mode_e m);
    return (m == MODE_FULL) || (m == MODE_ACT) || (m == MODE_NOPLL);
  endfunction

endpackage

// File: rtl/pms_req_gate.sv
`timescale 1ns/1ps
module pms_req_gate
  import pms_pkg::*;
(
  input  logic                 idle_i,
  input  pm_mode_e             cur_mode_i,
  input  logic                 req_valid_i,
  input  logic [MODE_W-1:0]    req_code_i,
  output logic                 accept_o,
  output pm_mode_e             target_o
);

  logic legal;

  always_comb begin
    unique case (req_code_i)
      3'd0:               legal = (cur_mode_i != MODE_FULL);
      3'd1:               legal = (cur_mode_i != MODE_ACT);
      3'd2:               legal = (cur_mode_i == MODE_ACT);
      3'd3, 3'd4, 3'd5:   legal = 1'b1;
      default:            legal = 1'b0;
    endcase
  end

  assign accept_o = req_valid_i && idle_i && is_run_mode(cur_mode_i) && legal;
  assign target_o = pm_mode_e'(req_code_i);

endmodule

// File: rtl/pms_mult_stage.sv
`timescale 1ns/1ps
module pms_mult_stage #(
  parameter int MULT_W   = 6,
  parameter int MULT_DEF = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MULT_W-1:0] wr_val_i,
  input  logic              apply_i,
  input  logic              restore_i,
  output logic [MULT_W-1:0] applied_o
);

  localparam logic [MULT_W-1:0] DEF_VAL = MULT_W'(MULT_DEF);

  logic [MULT_W-1:0] staged_q;
  logic [MULT_W-1:0] applied_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q  <= DEF_VAL;
      applied_q <= DEF_VAL;
    end else if (restore_i) begin
      staged_q  <= DEF_VAL;
      applied_q <= DEF_VAL;
    end else begin
      if (wr_i)    staged_q  <= wr_val_i;
      if (apply_i) applied_q <= staged_q;
    end
  end

  assign applied_o = applied_q;

  assert_mult_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!apply_i && !restore_i) |=> $stable(applied_o));

  assert_mult_default_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (applied_o == DEF_VAL));

endmodule

// File: rtl/pms_seq_fsm.sv
`timescale 1ns/1ps
module pms_seq_fsm
  import pms_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      accept_i,
  input  pm_mode_e  target_i,
  input  logic      pll_lock_i,
  input  logic      sr_ack_i,
  input  logic      vint_ok_i,
  input  logic      irq_wake_i,
  input  logic      rtc_wake_i,
  output pwr_ctl_t  ctl_o,
  output pm_mode_e  mode_o,
  output logic      idle_o,
  output logic      dma_ok_o,
  output logic      mult_apply_o,
  output logic      mult_restore_o
);

  seq_step_e step_q;
  pm_mode_e  mode_q, goal_q;
  pwr_ctl_t  ctl_q;
  logic      dma_q;
  logic      wake;

  // deep sleep listens to the RTC only
  assign wake = rtc_wake_i || (irq_wake_i && (mode_q != MODE_DEEP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= SEQ_IDLE;
      mode_q <= MODE_FULL;
      goal_q <= MODE_FULL;
      ctl_q  <= CTL_RESET;
      dma_q  <= 1'b1;
    end else begin
      unique case (step_q)
        SEQ_IDLE: if (accept_i) begin
          goal_q <= target_i;
          unique case (target_i)
            MODE_FULL: begin
              ctl_q.pll_en <= 1'b1;
              step_q       <= SEQ_LOCK;
            end
            MODE_ACT: begin
              if (mode_q == MODE_NOPLL) begin
                ctl_q.pll_en <= 1'b1;
                step_q       <= SEQ_LOCK;
              end else begin
                ctl_q.pll_bypass <= 1'b1;
                mode_q           <= MODE_ACT;
              end
            end
            MODE_NOPLL: begin
              ctl_q.pll_en <= 1'b0;
              mode_q       <= MODE_NOPLL;
            end
            default: begin
              ctl_q.sr_req <= 1'b1;
              dma_q        <= 1'b0;
              step_q       <= SEQ_SR_IN;
            end
          endcase
        end
        SEQ_LOCK: if (pll_lock_i) begin
          if (goal_q == MODE_FULL) ctl_q.pll_bypass <= 1'b0;
          if (ctl_q.sr_req) begin
            ctl_q.sr_req <= 1'b0;
            step_q       <= SEQ_SR_OUT;
          end else begin
            mode_q <= goal_q;
            step_q <= SEQ_IDLE;
          end
        end
        SEQ_SR_IN: if (sr_ack_i) begin
          mode_q        <= goal_q;
          ctl_q.cclk_en <= 1'b0;
          unique case (goal_q)
            MODE_SLEEP: ctl_q.sclk_slow <= 1'b1;
            MODE_DEEP:  ctl_q.sclk_en   <= 1'b0;
            default: begin
              ctl_q.sclk_en    <= 1'b0;
              ctl_q.pll_en     <= 1'b0;
              ctl_q.pll_bypass <= 1'b1;
              ctl_q.vint_en    <= 1'b0;
            end
          endcase
          step_q <= SEQ_PARKED;
        end
        SEQ_PARKED: if (wake) begin
          goal_q <= MODE_FULL;
          if (mode_q == MODE_HIBER) begin
            ctl_q.vint_en <= 1'b1;
            step_q        <= SEQ_VINT_UP;
          end else begin
            ctl_q.cclk_en    <= 1'b1;
            ctl_q.sclk_en    <= 1'b1;
            ctl_q.sclk_slow  <= 1'b0;
            ctl_q.pll_en     <= 1'b1;
            ctl_q.pll_bypass <= 1'b1;
            step_q           <= SEQ_LOCK;
          end
        end
        SEQ_VINT_UP: if (vint_ok_i) begin
          ctl_q.cclk_en    <= 1'b1;
          ctl_q.sclk_en    <= 1'b1;
          ctl_q.sclk_slow  <= 1'b0;
          ctl_q.pll_en     <= 1'b1;
          ctl_q.pll_bypass <= 1'b1;
          step_q           <= SEQ_LOCK;
        end
        SEQ_SR_OUT: if (!sr_ack_i) begin
          mode_q <= MODE_FULL;
          dma_q  <= 1'b1;
          step_q <= SEQ_IDLE;
        end
        default: step_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ctl_o          = ctl_q;
  assign mode_o         = mode_q;
  assign idle_o         = (step_q == SEQ_IDLE);
  assign dma_ok_o       = dma_q;
  assign mult_apply_o   = (step_q == SEQ_IDLE) && accept_i && (target_i == MODE_FULL);
  assign mult_restore_o = (step_q == SEQ_VINT_UP) && vint_ok_i;

  assert_gate_after_sr_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_q.cclk_en) |-> ($past(sr_ack_i) && ctl_q.sr_req));

  assert_no_dma_when_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.cclk_en |-> !dma_q);

  assert_sr_release_late_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_q.sr_req) |-> (ctl_q.cclk_en && ctl_q.sclk_en && $past(pll_lock_i)));

  assert_deep_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == SEQ_PARKED && mode_q == MODE_DEEP && !rtc_wake_i) |=> (step_q == SEQ_PARKED));

  assert_supply_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.vint_en |-> (!ctl_q.cclk_en && !ctl_q.sclk_en && !ctl_q.pll_en));

  assert_full_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == SEQ_IDLE && mode_q == MODE_FULL) |->
      (ctl_q.pll_en && !ctl_q.pll_bypass && ctl_q.cclk_en && ctl_q.sclk_en));

endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int MULT_W   = 6,
  parameter int MULT_DEF = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [2:0]           req_mode_i,
  input  logic                 mult_we_i,
  input  logic [MULT_W-1:0]    mult_i,
  input  logic                 irq_wake_i,
  input  logic                 rtc_wake_i,
  input  logic                 pll_lock_i,
  input  logic                 sr_ack_i,
  input  logic                 vint_ok_i,
  output logic                 pll_en_o,
  output logic                 pll_bypass_o,
  output logic                 cclk_en_o,
  output logic                 sclk_en_o,
  output logic                 sclk_slow_o,
  output logic                 vint_en_o,
  output logic                 sr_req_o,
  output logic [MULT_W-1:0]    mult_o,
  output logic [2:0]           mode_o,
  output logic                 idle_o,
  output logic                 dma_l1_ok_o
);

  logic     accept, idle, apply, restore, mult_wr;
  pm_mode_e target, mode;
  pwr_ctl_t ctl;

  pms_req_gate u_gate (
    .idle_i      (idle),
    .cur_mode_i  (mode),
    .req_valid_i (req_valid_i),
    .req_code_i  (req_mode_i),
    .accept_o    (accept),
    .target_o    (target)
  );

  pms_seq_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .accept_i       (accept),
    .target_i       (target),
    .pll_lock_i     (pll_lock_i),
    .sr_ack_i       (sr_ack_i),
    .vint_ok_i      (vint_ok_i),
    .irq_wake_i     (irq_wake_i),
    .rtc_wake_i     (rtc_wake_i),
    .ctl_o          (ctl),
    .mode_o         (mode),
    .idle_o         (idle),
    .dma_ok_o       (dma_l1_ok_o),
    .mult_apply_o   (apply),
    .mult_restore_o (restore)
  );

  assign mult_wr = mult_we_i && idle && ((mode == MODE_ACT) || (mode == MODE_NOPLL));

  pms_mult_stage #(.MULT_W(MULT_W), .MULT_DEF(MULT_DEF)) u_mult (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (mult_wr),
    .wr_val_i  (mult_i),
    .apply_i   (apply),
    .restore_i (restore),
    .applied_o (mult_o)
  );

  assign pll_en_o     = ctl.pll_en;
  assign pll_bypass_o = ctl.pll_bypass;
  assign cclk_en_o    = ctl.cclk_en;
  assign sclk_en_o    = ctl.sclk_en;
  assign sclk_slow_o  = ctl.sclk_slow;
  assign vint_en_o    = ctl.vint_en;
  assign sr_req_o     = ctl.sr_req;
  assign mode_o       = mode;
  assign idle_o       = idle;

endmodule

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;

  localparam int MW  = 6;
  localparam int DEF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic mult_we = 1'b0;
  logic [MW-1:0] mult_val = '0;
  logic irq = 1'b0, rtc = 1'b0;
  logic pll_lock, sr_ack, vint_ok;
  logic pll_en, pll_byp, cclk_en, sclk_en, sclk_slow, vint_en, sr_req, idle, dma_ok;
  logic [MW-1:0] mult_o;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwr_mode_seq #(.MULT_W(MW), .MULT_DEF(DEF)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .mult_we_i(mult_we), .mult_i(mult_val), .irq_wake_i(irq), .rtc_wake_i(rtc),
    .pll_lock_i(pll_lock), .sr_ack_i(sr_ack), .vint_ok_i(vint_ok),
    .pll_en_o(pll_en), .pll_bypass_o(pll_byp), .cclk_en_o(cclk_en), .sclk_en_o(sclk_en),
    .sclk_slow_o(sclk_slow), .vint_en_o(vint_en), .sr_req_o(sr_req), .mult_o(mult_o),
    .mode_o(mode), .idle_o(idle), .dma_l1_ok_o(dma_ok)
  );

  // acknowledge models with a few cycles of latency
  logic [3:0] pll_sh;
  logic [1:0] sr_sh, vint_sh;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_sh  <= '1;
      sr_sh   <= '0;
      vint_sh <= '1;
    end else begin
      pll_sh  <= pll_en ? {pll_sh[2:0], 1'b1} : '0;
      sr_sh   <= {sr_sh[0], sr_req};
      vint_sh <= vint_en ? {vint_sh[0], 1'b1} : '0;
    end
  end
  assign pll_lock = pll_sh[3] && pll_en;
  assign sr_ack   = sr_sh[1];
  assign vint_ok  = vint_sh[1] && vint_en;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic request(input logic [2:0] m);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_mult(input logic [MW-1:0] v);
    @(negedge clk);
    mult_we  = 1'b1;
    mult_val = v;
    @(negedge clk);
    mult_we  = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (!idle && n < 60) begin
      @(negedge clk);
      n++;
    end
    if (!idle) chk({tag, " idle timeout"}, 0, 1);
  endtask

  task automatic wait_gated(input string tag);
    int n = 0;
    while (cclk_en && n < 60) begin
      @(negedge clk);
      n++;
    end
    if (cclk_en) chk({tag, " gate timeout"}, 1, 0);
  endtask

  task automatic pulse(input bit use_rtc);
    @(negedge clk);
    if (use_rtc) rtc = 1'b1; else irq = 1'b1;
    @(negedge clk);
    rtc = 1'b0;
    irq = 1'b0;
  endtask

  task automatic chk_reset_state(input string tag);
    chk({tag, " mode"}, mode, 0);
    chk({tag, " idle"}, idle, 1);
    chk({tag, " pll_en"}, pll_en, 1);
    chk({tag, " bypass"}, pll_byp, 0);
    chk({tag, " cclk"}, cclk_en, 1);
    chk({tag, " sclk"}, sclk_en, 1);
    chk({tag, " slow"}, sclk_slow, 0);
    chk({tag, " vint"}, vint_en, 1);
    chk({tag, " sr_req"}, sr_req, 0);
    chk({tag, " dma"}, dma_ok, 1);
    chk({tag, " mult"}, mult_o, DEF);
  endtask

  typedef struct packed {
    logic       rv;
    logic [2:0] rm;
    logic       we;
    logic [5:0] wv;
    logic [2:0] em;
    logic       epll;
    logic       ebyp;
    logic [5:0] emult;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd1, 1'b0, 6'd0,  3'd1, 1'b1, 1'b1, 6'd8},   // R2 full -> bypassed
    '{1'b0, 3'd0, 1'b1, 6'd12, 3'd1, 1'b1, 1'b1, 6'd8},   // R4 staged only
    '{1'b1, 3'd0, 1'b0, 6'd0,  3'd0, 1'b1, 1'b0, 6'd12},  // R4 applied on full entry
    '{1'b0, 3'd0, 1'b1, 6'd20, 3'd0, 1'b1, 1'b0, 6'd12},  // R4 write in full ignored
    '{1'b1, 3'd2, 1'b0, 6'd0,  3'd0, 1'b1, 1'b0, 6'd12},  // R3 pll-off from full ignored
    '{1'b1, 3'd1, 1'b0, 6'd0,  3'd1, 1'b1, 1'b1, 6'd12},  // R2
    '{1'b1, 3'd0, 1'b0, 6'd0,  3'd0, 1'b1, 1'b0, 6'd12},  // R4 value 20 never staged
    '{1'b1, 3'd1, 1'b0, 6'd0,  3'd1, 1'b1, 1'b1, 6'd12},  // R2
    '{1'b1, 3'd2, 1'b0, 6'd0,  3'd2, 1'b0, 1'b1, 6'd12},  // R3 pll off
    '{1'b0, 3'd0, 1'b1, 6'd30, 3'd2, 1'b0, 1'b1, 6'd12},  // R4 write in pll-off
    '{1'b1, 3'd7, 1'b0, 6'd0,  3'd2, 1'b0, 1'b1, 6'd12},  // R9 invalid code
    '{1'b1, 3'd2, 1'b0, 6'd0,  3'd2, 1'b0, 1'b1, 6'd12},  // R9 same mode
    '{1'b1, 3'd1, 1'b0, 6'd0,  3'd1, 1'b1, 1'b1, 6'd12},  // R3 relock to bypassed
    '{1'b1, 3'd0, 1'b0, 6'd0,  3'd0, 1'b1, 1'b0, 6'd30}   // R4
  };

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic prev_sr;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_reset_state("R1");

    // table walk through the run modes
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rv) request(VECS[i].rm);
      if (VECS[i].we) write_mult(VECS[i].wv);
      wait_idle("table");
      chk($sformatf("vec%0d mode", i), mode, VECS[i].em);
      chk($sformatf("vec%0d pll_en", i), pll_en, VECS[i].epll);
      chk($sformatf("vec%0d bypass", i), pll_byp, VECS[i].ebyp);
      chk($sformatf("vec%0d mult", i), mult_o, VECS[i].emult);
      chk($sformatf("vec%0d clocks+dma", i), {cclk_en, sclk_en, dma_ok}, 3'b111);
    end

    // R5 sleep entry ordering
    request(3'd3);
    chk("R5 sr_req raised first", sr_req, 1);
    chk("R5 core clock still on", cclk_en, 1);
    chk("R5 dma refused", dma_ok, 0);
    wait_gated("R5");
    chk("R5 mode", mode, 3);
    chk("R5 sclk on", sclk_en, 1);
    chk("R5 slow", sclk_slow, 1);
    chk("R5 pll kept", pll_en, 1);
    chk("R5 sr ack seen", sr_ack, 1);

    // R9 request while parked
    request(3'd1);
    repeat (4) @(negedge clk);
    chk("R9 parked request ignored", {mode, cclk_en}, {3'd3, 1'b0});

    // R8 wake from sleep by interrupt
    pulse(1'b0);
    prev_sr = sr_req;
    for (int n = 0; n < 60 && !idle; n++) begin
      if (prev_sr && !sr_req)
        chk("R8 clocks+lock before sr release", {cclk_en, sclk_en, pll_en, pll_byp}, 4'b1110);
      prev_sr = sr_req;
      @(negedge clk);
    end
    chk("R8 back to full", mode, 0);
    chk("R8 sr released", sr_req, 0);
    chk("R8 dma allowed", dma_ok, 1);

    // R6 deep sleep ignores interrupts
    request(3'd4);
    wait_gated("R6");
    chk("R6 mode", mode, 4);
    chk("R6 sclk gated", sclk_en, 0);
    pulse(1'b0);
    repeat (8) @(negedge clk);
    chk("R6 irq ignored", {mode, cclk_en, sclk_en}, {3'd4, 1'b0, 1'b0});
    pulse(1'b1);
    wait_idle("R6");
    chk("R6 rtc wake", {mode, cclk_en, sclk_en, sr_req}, {3'd0, 1'b1, 1'b1, 1'b0});

    // R7 hibernate with non-default multiplier
    request(3'd1);
    wait_idle("R7");
    write_mult(6'd40);
    request(3'd0);
    wait_idle("R7");
    chk("R7 mult before", mult_o, 40);
    request(3'd5);
    wait_gated("R7");
    chk("R7 supply off", vint_en, 0);
    chk("R7 pll off", pll_en, 0);
    chk("R7 sclk off", sclk_en, 0);
    chk("R7 mode", mode, 5);
    pulse(1'b0);
    for (int n = 0; n < 60 && !vint_en; n++) @(negedge clk);
    chk("R7 supply before clocks", {vint_en, cclk_en}, 2'b10);
    for (int n = 0; n < 60 && !cclk_en; n++) @(negedge clk);
    chk("R7 supply good before clocks", vint_ok, 1);
    wait_idle("R7");
    chk("R7 back to full", mode, 0);
    chk("R7 mult default", mult_o, DEF);
    request(3'd1);
    wait_idle("R7");
    request(3'd0);
    wait_idle("R7");
    chk("R7 staged default", mult_o, DEF);

    // R9 request during a transition
    request(3'd1);
    wait_idle("R9");
    request(3'd2);
    wait_idle("R9");
    request(3'd0);
    chk("R9 busy", idle, 0);
    request(3'd3);
    wait_idle("R9");
    chk("R9 busy request dropped", {mode, sr_req, cclk_en}, {3'd0, 1'b0, 1'b1});

    // R10 reset from sleep
    request(3'd1);
    wait_idle("R10");
    write_mult(6'd50);
    request(3'd0);
    wait_idle("R10");
    chk("R10 mult set", mult_o, 50);
    request(3'd3);
    wait_gated("R10");
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_reset_state("R10");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule